// File: doc/BRIEF.md
# Reset and Clock Scaling Controller

This block sits between a fast oscillator and a processor core. All of its logic runs on the oscillator clock. It produces a divided processor clock in two forms: a one-cycle enable for logic on the oscillator clock, and a registered square wave that can be driven off chip. It also produces an auxiliary fast-clock enable. A two-bit scale field selects the divide ratio. The field is loaded by a configuration write, and the write is honoured only when a privilege qualifier is high. A new ratio takes effect only at the end of the current divided period, so no period is ever cut short.

The block also sequences the core reset. The external active-low reset passes through a two-flop synchronizer. It is then sampled once per divided period, on the falling edge of the divided clock. A low sample puts the core into reset at the next oscillator edge. Entering reset produces two clear pulses: one for the edge-triggered interrupt latch and one for the status registers. While the core is in reset, the block drives the bus controls to their quiet states, runs the auxiliary enable at full rate, and forces the scale back to its fastest setting. The core leaves reset eight divided cycles after the reset input is seen high again. At that point a start strobe tells the core to fetch from its boot address. A reset pulse with fewer than 64 low samples is flagged on an error output, but it still holds the core in reset for as long as it lasts.

A separate power-on input initialises the controller's own flops. It stands in for the voltage monitor, which sits outside this block.

Top module: `clkrst_ctrl`

## Requirements
- R1: The divided clock `cttl` has a period of 2·2^s oscillator cycles for scale code s. The codes are 00 = ÷1, 01 = ÷2, 10 = ÷4 and 11 = ÷8 applied on top of the half-rate clock, giving periods of 2, 4, 8 and 16 cycles. `cttl` is high for the first half of each period. `cpu_ce` pulses for one cycle per period, in the first high cycle.
- R2: A scale write is accepted only in a cycle where `cfg_we` and `cfg_sup` are both high. The new ratio takes effect only at a period boundary.
- R3: Power-on reset sets the scale to 00. Core reset also forces the scale to 00, effective at the next period boundary. The scale stays at 00 after release.
- R4: `rst_in_n` is synchronized through two flops and sampled in the cycle of each falling edge of `cttl`. A low sample raises `core_rst` at the next oscillator edge. At ÷8 this happens no later than 18 oscillator cycles after `rst_in_n` falls.
- R5: `core_rst` falls on the 8th falling edge of `cttl` at which the synchronized reset input is sampled high. At ÷1 this is 17 or 18 oscillator cycles after `rst_in_n` rises.
- R6: `fetch_start` pulses for exactly one cycle, in the cycle `core_rst` first reads low, and once per release.
- R7: `nmi_clr` and `stat_clr` each pulse for exactly one cycle when the core enters reset from run or release.
- R8: `short_rst` goes high when a reset ends with fewer than 64 low samples. It returns low when the next reset begins. A reset with 64 or more low samples leaves it low.
- R9: `bus_idle`, `ad_hiz` and `ale_hi` are high exactly while `core_rst` is high.
- R10: `fclk_ce` is high in every cycle while `core_rst` is high. Outside reset it pulses once every 2^s cycles, which is twice per `cttl` period.
- R11: While `por_n` is low: `core_rst` = 1, `cttl` = 1, the bus controls = 1, `short_rst` = 0 and `fetch_start` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; all logic runs on it |
| por_n | input | 1 | Power-on initialisation of the controller, active low, asynchronous |
| rst_in_n | input | 1 | External reset request, active low, asynchronous to the clock |
| cfg_we | input | 1 | Scale field write strobe |
| cfg_sup | input | 1 | Privilege qualifier for the scale write |
| cfg_scale | input | 2 | New scale code |
| cpu_ce | output | 1 | One-cycle enable per divided period |
| cttl | output | 1 | Registered divided clock |
| fclk_ce | output | 1 | Auxiliary fast-clock enable |
| core_rst | output | 1 | Core reset, active high |
| nmi_clr | output | 1 | Clear pulse for the interrupt edge latch |
| stat_clr | output | 1 | Clear pulse for the status registers |
| fetch_start | output | 1 | Strobe to start fetching from the boot address |
| bus_idle | output | 1 | Force the bus strobes inactive |
| ad_hiz | output | 1 | Float the address/data lines |
| ale_hi | output | 1 | Hold the address latch enable high |
| short_rst | output | 1 | Last reset was shorter than 64 samples |

## Verification
Some properties are checked on every cycle. A ratio may change only at a period boundary, and an unprivileged write must leave the pending scale untouched. The clear pulses must coincide with reset entry. The start strobe must follow the release edge, and release may occur only after a sample strobe. The error flag may rise only on leaving the low-sample phase.

Other behaviour only the bench scenarios can show. These are the actual period lengths for each scale code, the exact entry and release latencies, and the reversion of the scale to ÷1 inside reset. The bench also shows that the error flag separates short pulses from long ones.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_REL  = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/clkrst_sync.sv
module clkrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/clkrst_div.sv
module clkrst_div #(
    parameter int SCALE_W = 2,
    parameter int CNT_W   = 1 << SCALE_W
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               core_rst,
    input  logic               cfg_we,
    input  logic               cfg_sup,
    input  logic [SCALE_W-1:0] cfg_scale,
    output logic               cttl,
    output logic               cpu_ce,
    output logic               fclk_ce,
    output logic               fall_stb
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [SCALE_W-1:0] act;
        logic [SCALE_W-1:0] pend;
        logic               cttl;
    } div_t;

    div_t div_d, div_q;

    function automatic logic [CNT_W-1:0] last_of(input logic [SCALE_W-1:0] s);
        return CNT_W'((2 << s) - 1);
    endfunction

    function automatic logic [CNT_W-1:0] half_of(input logic [SCALE_W-1:0] s);
        return CNT_W'(1 << s);
    endfunction

    function automatic logic [CNT_W-1:0] mask_of(input logic [SCALE_W-1:0] s);
        return CNT_W'((1 << s) - 1);
    endfunction

    always_comb begin
        div_d = div_q;
        if (div_q.cnt == last_of(div_q.act)) begin
            div_d.cnt = '0;
            div_d.act = div_q.pend;
        end else begin
            div_d.cnt = div_q.cnt + CNT_W'(1);
        end
        if (core_rst)                div_d.pend = '0;
        else if (cfg_we && cfg_sup)  div_d.pend = cfg_scale;
        div_d.cttl = (div_d.cnt < half_of(div_d.act));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            div_q.cnt  <= '0;
            div_q.act  <= '0;
            div_q.pend <= '0;
            div_q.cttl <= 1'b1;
        end else begin
            div_q <= div_d;
        end
    end

    assign cttl     = div_q.cttl;
    assign cpu_ce   = (div_q.cnt == '0);
    assign fall_stb = (div_q.cnt == half_of(div_q.act));
    assign fclk_ce  = core_rst || ((div_q.cnt & mask_of(div_q.act)) == '0);

    // R2: ratio only changes at a period boundary
    assert_ratio_boundary_R2: assert property (@(posedge clk) disable iff (!por_n)
        !$stable(div_q.act) |-> (div_q.cnt == '0));

    // R2: an unprivileged write leaves the pending scale alone
    assert_priv_gate_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_sup && !core_rst) |=> $stable(div_q.pend));

    // R1: every rising edge of cttl carries the cpu enable
    assert_ce_on_rise_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(div_q.cttl) |-> cpu_ce);
endmodule

// File: rtl/clkrst_seq.sv
module clkrst_seq
    import clkrst_pkg::*;
#(
    parameter int MIN_LOW = 64,
    parameter int REL_CYC = 8,
    parameter int LOW_W   = $clog2(MIN_LOW + 1),
    parameter int REL_W   = $clog2(REL_CYC + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_sync_n,
    input  logic fall_stb,
    output logic core_rst,
    output logic nmi_clr,
    output logic stat_clr,
    output logic fetch_start,
    output logic short_rst
);
    typedef struct packed {
        seq_state_e       state;
        logic [LOW_W-1:0] low_cnt;
        logic [REL_W-1:0] rel_cnt;
        logic             core_rst;
        logic             nmi_clr;
        logic             stat_clr;
        logic             start;
        logic             short_flag;
    } seq_t;

    seq_t seq_d, seq_q;
    logic enter_hold;

    always_comb begin
        seq_d          = seq_q;
        seq_d.nmi_clr  = 1'b0;
        seq_d.stat_clr = 1'b0;
        enter_hold     = 1'b0;
        if (fall_stb) begin
            case (seq_q.state)
                SEQ_HOLD: begin
                    if (!rst_sync_n) begin
                        if (seq_q.low_cnt != LOW_W'(MIN_LOW))
                            seq_d.low_cnt = seq_q.low_cnt + LOW_W'(1);
                    end else begin
                        seq_d.short_flag = (seq_q.low_cnt < LOW_W'(MIN_LOW));
                        seq_d.state      = SEQ_REL;
                        seq_d.rel_cnt    = REL_W'(1);
                    end
                end
                SEQ_REL: begin
                    if (!rst_sync_n)
                        enter_hold = 1'b1;
                    else if (seq_q.rel_cnt == REL_W'(REL_CYC - 1))
                        seq_d.state = SEQ_RUN;
                    else
                        seq_d.rel_cnt = seq_q.rel_cnt + REL_W'(1);
                end
                default: begin
                    if (!rst_sync_n) enter_hold = 1'b1;
                end
            endcase
        end
        if (enter_hold) begin
            seq_d.state      = SEQ_HOLD;
            seq_d.low_cnt    = LOW_W'(1);
            seq_d.short_flag = 1'b0;
            seq_d.nmi_clr    = 1'b1;
            seq_d.stat_clr   = 1'b1;
        end
        seq_d.start    = (seq_q.state == SEQ_REL) && (seq_d.state == SEQ_RUN);
        seq_d.core_rst = (seq_d.state != SEQ_RUN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q.state      <= SEQ_HOLD;
            seq_q.low_cnt    <= '0;
            seq_q.rel_cnt    <= '0;
            seq_q.core_rst   <= 1'b1;
            seq_q.nmi_clr    <= 1'b0;
            seq_q.stat_clr   <= 1'b0;
            seq_q.start      <= 1'b0;
            seq_q.short_flag <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign core_rst    = seq_q.core_rst;
    assign nmi_clr     = seq_q.nmi_clr;
    assign stat_clr    = seq_q.stat_clr;
    assign fetch_start = seq_q.start;
    assign short_rst   = seq_q.short_flag;

    // R5: release happens only on a sample strobe
    assert_release_on_strobe_R5: assert property (@(posedge clk) disable iff (!por_n)
        $fell(seq_q.core_rst) |-> $past(fall_stb));

    // R6: start strobe marks the release edge
    assert_start_at_release_R6: assert property (@(posedge clk) disable iff (!por_n)
        seq_q.start |-> (!seq_q.core_rst && $past(seq_q.core_rst)));

    // R7: clear pulses accompany reset entry from run
    assert_clear_on_entry_R7: assert property (@(posedge clk) disable iff (!por_n)
        $rose(seq_q.core_rst) |-> (seq_q.nmi_clr && seq_q.stat_clr));

    // R8: the error flag rises only when leaving the low phase
    assert_short_on_exit_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(seq_q.short_flag) |-> (seq_q.state == SEQ_REL));
endmodule

// File: rtl/clkrst_ctrl.sv
module clkrst_ctrl #(
    parameter int SCALE_W   = 2,
    parameter int SYNC_STG  = 2,
    parameter int MIN_LOW   = 64,
    parameter int REL_CYC   = 8
) (
    input  logic               clk_osc,
    input  logic               por_n,
    input  logic               rst_in_n,
    input  logic               cfg_we,
    input  logic               cfg_sup,
    input  logic [SCALE_W-1:0] cfg_scale,
    output logic               cpu_ce,
    output logic               cttl,
    output logic               fclk_ce,
    output logic               core_rst,
    output logic               nmi_clr,
    output logic               stat_clr,
    output logic               fetch_start,
    output logic               bus_idle,
    output logic               ad_hiz,
    output logic               ale_hi,
    output logic               short_rst
);
    localparam int CNT_W = 1 << SCALE_W;

    logic rst_sync_n;
    logic fall_stb;

    clkrst_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk_osc),
        .por_n (por_n),
        .din   (rst_in_n),
        .dout  (rst_sync_n)
    );

    clkrst_div #(.SCALE_W(SCALE_W), .CNT_W(CNT_W)) u_div (
        .clk       (clk_osc),
        .por_n     (por_n),
        .core_rst  (core_rst),
        .cfg_we    (cfg_we),
        .cfg_sup   (cfg_sup),
        .cfg_scale (cfg_scale),
        .cttl      (cttl),
        .cpu_ce    (cpu_ce),
        .fclk_ce   (fclk_ce),
        .fall_stb  (fall_stb)
    );

    clkrst_seq #(.MIN_LOW(MIN_LOW), .REL_CYC(REL_CYC)) u_seq (
        .clk         (clk_osc),
        .por_n       (por_n),
        .rst_sync_n  (rst_sync_n),
        .fall_stb    (fall_stb),
        .core_rst    (core_rst),
        .nmi_clr     (nmi_clr),
        .stat_clr    (stat_clr),
        .fetch_start (fetch_start),
        .short_rst   (short_rst)
    );

    assign bus_idle = core_rst;
    assign ad_hiz   = core_rst;
    assign ale_hi   = core_rst;

    // R10: the cpu enable in run always lines up with an auxiliary enable
    assert_fclk_aligned_R10: assert property (@(posedge clk_osc) disable iff (!por_n)
        (cpu_ce && !core_rst) |-> fclk_ce);
endmodule

// File: tb/tb_clkrst_ctrl.sv
`timescale 1ns/1ps
module tb_clkrst_ctrl;
    logic       clk_osc = 1'b0;
    logic       por_n, rst_in_n, cfg_we, cfg_sup;
    logic [1:0] cfg_scale;
    logic cpu_ce, cttl, fclk_ce, core_rst, nmi_clr, stat_clr, fetch_start;
    logic bus_idle, ad_hiz, ale_hi, short_rst;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk_osc = ~clk_osc;

    clkrst_ctrl dut (
        .clk_osc(clk_osc), .por_n(por_n), .rst_in_n(rst_in_n),
        .cfg_we(cfg_we), .cfg_sup(cfg_sup), .cfg_scale(cfg_scale),
        .cpu_ce(cpu_ce), .cttl(cttl), .fclk_ce(fclk_ce), .core_rst(core_rst),
        .nmi_clr(nmi_clr), .stat_clr(stat_clr), .fetch_start(fetch_start),
        .bus_idle(bus_idle), .ad_hiz(ad_hiz), .ale_hi(ale_hi), .short_rst(short_rst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_osc);
    endtask

    // Monitor: measures cttl periods and pops expectations
    int per_cnt = 0;
    bit seen_rise = 1'b0;
    bit prev_cttl = 1'b0;
    always @(negedge clk_osc) begin
        per_cnt = per_cnt + 1;
        if (cttl && !prev_cttl) begin
            if (seen_rise && exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(per_cnt == e, t, per_cnt, e);
            end
            per_cnt = 0;
            seen_rise = 1'b1;
        end
        prev_cttl = cttl;
    end

    // Driver side of the scoreboard
    task automatic expect_period(input int p, input string tag);
        exp_q.push_back(p);
        tag_q.push_back(tag);
        for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk_osc);
        if (exp_q.size() > 0) begin
            chk(1'b0, {tag, " period not observed"}, 0, p);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic write_scale(input logic [1:0] s, input logic sup);
        cfg_scale = s; cfg_sup = sup; cfg_we = 1'b1;
        @(negedge clk_osc);
        cfg_we = 1'b0; cfg_sup = 1'b0;
    endtask

    task automatic release_reset(input bit exp_short);
        int n;
        n = 0;
        rst_in_n = 1'b1;
        while (n < 200) begin
            @(negedge clk_osc);
            n++;
            if (!core_rst) break;
        end
        chk(n == 17 || n == 18, "R5 release latency", n, 17);
        chk(fetch_start == 1'b1, "R6 start strobe at release", fetch_start, 1);
        chk(bus_idle == 0 && ad_hiz == 0 && ale_hi == 0, "R9 bus controls off in run",
            {bus_idle, ad_hiz, ale_hi}, 0);
        chk(short_rst == exp_short, "R8 short flag after release", short_rst, exp_short);
        @(negedge clk_osc);
        chk(fetch_start == 1'b0, "R6 start strobe one cycle", fetch_start, 0);
        begin
            int extra;
            extra = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk_osc);
                if (fetch_start) extra++;
            end
            chk(extra == 0, "R6 no repeated start strobe", extra, 0);
        end
    endtask

    task automatic fclk_in_reset(input string tag);
        int miss;
        miss = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_osc);
            if (!fclk_ce) miss++;
        end
        chk(miss == 0, tag, miss, 0);
    endtask

    initial begin
        por_n = 1'b0; rst_in_n = 1'b0; cfg_we = 1'b0; cfg_sup = 1'b0; cfg_scale = 2'b00;
        tick(4);
        // R11 reset state
        chk(core_rst == 1'b1, "R11 core_rst in por", core_rst, 1);
        chk(cttl == 1'b1, "R11 cttl in por", cttl, 1);
        chk(bus_idle && ad_hiz && ale_hi, "R11 bus controls in por", {bus_idle, ad_hiz, ale_hi}, 7);
        chk(short_rst == 1'b0 && fetch_start == 1'b0, "R11 flags in por", {short_rst, fetch_start}, 0);
        por_n = 1'b1;
        tick(10);
        expect_period(2, "R3 period after power-on");
        fclk_in_reset("R10 fclk every cycle in reset");
        chk(bus_idle && ad_hiz && ale_hi, "R9 bus controls in reset", {bus_idle, ad_hiz, ale_hi}, 7);
        tick(170);
        release_reset(1'b0);

        // Scale codes
        write_scale(2'b01, 1'b1);
        tick(20);
        expect_period(4, "R1 period code 01");
        write_scale(2'b11, 1'b0);
        tick(20);
        expect_period(4, "R2 unprivileged write ignored");
        write_scale(2'b11, 1'b1);
        tick(40);
        expect_period(16, "R1 period code 11");
        write_scale(2'b10, 1'b1);
        tick(40);
        expect_period(8, "R1 period code 10");
        begin
            int nf, nc;
            nf = 0; nc = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk_osc);
                if (fclk_ce) nf++;
                if (cpu_ce) nc++;
            end
            chk(nf == 2, "R10 fclk pulses per period at code 10", nf, 2);
            chk(nc == 1, "R1 cpu_ce pulses per period at code 10", nc, 1);
        end

        // Reset entry at code 11
        write_scale(2'b11, 1'b1);
        tick(40);
        begin
            int n, nn, ns;
            n = 0; nn = 0; ns = 0;
            rst_in_n = 1'b0;
            while (n < 100) begin
                @(negedge clk_osc);
                n++;
                if (nmi_clr) nn++;
                if (stat_clr) ns++;
                if (core_rst) break;
            end
            chk(n >= 3 && n <= 18, "R4 entry latency at code 11", n, 18);
            for (int i = 0; i < 30; i++) begin
                @(negedge clk_osc);
                if (nmi_clr) nn++;
                if (stat_clr) ns++;
            end
            chk(nn == 1, "R7 nmi_clr single pulse", nn, 1);
            chk(ns == 1, "R7 stat_clr single pulse", ns, 1);
        end
        expect_period(2, "R3 scale forced fastest in reset");
        fclk_in_reset("R10 fclk every cycle in second reset");
        tick(160);
        release_reset(1'b0);
        expect_period(2, "R3 scale stays fastest after release");

        // Short reset
        rst_in_n = 1'b0;
        tick(60);
        release_reset(1'b1);
        // Long reset clears the flag
        rst_in_n = 1'b0;
        tick(12);
        chk(core_rst == 1'b1, "R4 reset entered at code 00", core_rst, 1);
        chk(short_rst == 1'b0, "R8 flag cleared on new reset", short_rst, 0);
        tick(200);
        release_reset(1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule